// File: doc/BRIEF.md
# Card Clock Divider and Gate

This block produces the card clock timing for an SD/MMC host controller. It runs on a fixed reference clock and never gates that clock. Instead it drives a one-cycle clock-enable (`card_ce`) that marks each rising edge of the card clock. It also drives a level (`card_phase`) that is high during the first half of every card clock period. A divide code k (0 to 7) sets the card clock period to 2^k reference cycles, so the slowest card clock is the reference divided by 128.

A register bus writes two things: the divide code, and a 4-bit control word. The control word carries a stop command (bit 0), a start command (bit 1), a start-operation request (bit 2) that travels with a start, and a controller reset (bit 3). The block reports whether the card clock runs (`clk_running`) and whether a reset is in progress (`resetting`). It sends a one-cycle `start_op` pulse to the command engine, aligned with the first card clock edge. Starts and stops are gated so that no runt pulse appears. A start waits for the divider to wrap. A stop waits for the low phase at the end of the current period.

The controller state machine has five states:
- OFF: the clock is stopped.
- ARM: a start is waiting for the divider to wrap.
- RUN: the clock is running.
- DRAIN: a stop is waiting for the end of the current period.
- RESET: the controller is resetting.

Its transitions are:
- OFF to ARM on a start.
- ARM to RUN at the divider wrap.
- ARM to OFF on a stop.
- RUN to DRAIN on a stop.
- DRAIN to OFF at the last count of the period.
- DRAIN to RUN on a start.
- Any state other than RESET to RESET on a reset command.
- RESET to OFF when the reset timer expires.

Top module: `cclk_gen`

## Requirements
- R1: While `rst_n` is low and after it is released, `card_ce`, `card_phase`, `clk_running`, `resetting` and `start_op` are all 0.
- R2: With divide code k, `card_ce` is high for one cycle every 2^k cycles while the clock runs. For k≥1, `card_phase` is high for the first 2^(k-1) cycles of each period, starting at the `card_ce` cycle. For k=0 it is high throughout.
- R3: A control write with bit 1 set (start) and bit 0 clear, made while the clock is off, raises `clk_running` in the same cycle as the first `card_ce`. If the divide code is written in the same cycle, this happens exactly 2^k cycles after the write edge.
- R4: A control write with bit 0 set (stop) keeps the clock running to the end of the current period. `clk_running` falls after the cycle in which the divider holds its last count, so for k≥1 `card_phase` was low in the last running cycle.
- R5: A stop written while a start is still waiting for the divider wrap cancels the start, and the clock never runs.
- R6: A write with both bit 0 and bit 1 set acts as a stop. Given while the clock is off, it leaves the clock off.
- R7: Bit 2 written together with a start produces a one-cycle `start_op`. From the off state, the pulse coincides with the first `card_ce`. While the clock already runs, the pulse appears in the cycle after the write edge and the divider is not restarted.
- R8: Writing the divide code restarts the divider at count zero. While the clock runs, `card_ce` is high in the first cycle after the write edge, and the new period applies from then on.
- R9: A control write with bit 3 set has priority over every other command. `clk_running` is 0 from the next cycle, `resetting` is high for `RST_CYCLES` cycles, control and divider writes during that time are ignored, and the clock is off afterwards.
- R10: A start written while a stop is waiting for the end of the period cancels the stop, and the card clock continues without a gap or a phase change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_we | input | 1 | Control word write strobe |
| ctrl_wdata | input | 4 | Control word: bit 0 stop, bit 1 start, bit 2 start operation, bit 3 reset |
| div_we | input | 1 | Divide code write strobe |
| div_wdata | input | DIV_W | Divide code k, period 2^k reference cycles |
| card_ce | output | 1 | One-cycle enable at each card clock rising edge |
| card_phase | output | 1 | Card clock level (high phase) |
| clk_running | output | 1 | Status: card clock is enabled |
| resetting | output | 1 | Status: controller reset in progress |
| start_op | output | 1 | One-cycle start request to the command engine |

## Verification
Every result has a known due cycle, counted from the reference edge that samples the write:
- The first `card_ce`, the rise of `clk_running` and an accompanying `start_op` come 2^k edges after a start that also writes the code.
- A divider restart or a `start_op` issued while running shows at the first edge after the write.
- A stop completes P−c edges later, where c is the divider count after the write edge and P = 2^k.
- A reset drops `clk_running` at the first edge and ends `resetting` after `RST_CYCLES` edges.

The bench queues each expected event with its due cycle before driving the write. A monitor sampling on the falling edge pops and compares every observed edge of `clk_running`, `resetting` and `start_op`, so early, late and unexpected events all count as mismatches. The bench also compares `card_ce` and `card_phase` cycle by cycle against the period measured from the last divide-code write.

// File: rtl/cclk_pkg.sv
package cclk_pkg;
    // control word bit positions (software-visible encoding)
    localparam int CTL_STOP  = 0;
    localparam int CTL_START = 1;
    localparam int CTL_OP    = 2;
    localparam int CTL_RST   = 3;
    localparam int CTL_W     = 4;

    typedef enum logic [2:0] {
        ST_OFF   = 3'd0,
        ST_ARM   = 3'd1,
        ST_RUN   = 3'd2,
        ST_DRAIN = 3'd3,
        ST_RESET = 3'd4
    } cclk_state_e;
endpackage

// File: rtl/cclk_divider.sv
module cclk_divider #(
    parameter int DIV_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             code_we,
    input  logic [DIV_W-1:0] code_wdata,
    input  logic             hold_clr,
    output logic [DIV_W-1:0] code,
    output logic             at_zero,
    output logic             at_last,
    output logic             phase_hi
);
    localparam int CNT_W = (1 << DIV_W) - 1;

    logic [DIV_W-1:0] code_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W:0]   period_w;
    logic [CNT_W-1:0] last_c;
    logic [CNT_W-1:0] half_c;

    assign period_w = {{CNT_W{1'b0}}, 1'b1} << code_q;
    assign last_c   = CNT_W'(period_w - 1'b1);
    assign half_c   = CNT_W'(period_w >> 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q <= '0;
            cnt_q  <= '0;
        end else begin
            if (code_we)
                code_q <= code_wdata;
            if (code_we || hold_clr || (cnt_q == last_c))
                cnt_q <= '0;
            else
                cnt_q <= cnt_q + 1'b1;
        end
    end

    assign code     = code_q;
    assign at_zero  = (cnt_q == '0);
    assign at_last  = (cnt_q == last_c);
    assign phase_hi = (code_q == '0) || (cnt_q < half_c);
endmodule

// File: rtl/cclk_rst_timer.sv
module cclk_rst_timer #(
    parameter int RST_CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);
    localparam int TW = (RST_CYCLES > 1) ? $clog2(RST_CYCLES) : 1;

    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!run)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

    assign expired = run && (cnt_q == TW'(RST_CYCLES - 1));
endmodule

// File: rtl/cclk_ctrl_fsm.sv
module cclk_ctrl_fsm
    import cclk_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_we,
    input  logic [CTL_W-1:0] ctrl_wdata,
    input  logic             at_zero,
    input  logic             at_last,
    input  logic             phase_hi,
    input  logic             rst_expired,
    output logic             card_ce,
    output logic             card_phase,
    output logic             clk_running,
    output logic             resetting,
    output logic             start_op
);
    cclk_state_e st_q, st_d;
    logic        arm_op_q, arm_op_d;
    logic        op_q, op_d;
    logic        wr_rst, wr_stop, wr_start, wr_op;

    assign wr_rst   = ctrl_we && ctrl_wdata[CTL_RST];
    assign wr_stop  = ctrl_we && ctrl_wdata[CTL_STOP] && !ctrl_wdata[CTL_RST];
    assign wr_start = ctrl_we && ctrl_wdata[CTL_START] && !ctrl_wdata[CTL_STOP]
                      && !ctrl_wdata[CTL_RST];
    assign wr_op    = wr_start && ctrl_wdata[CTL_OP];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= ST_OFF;
            arm_op_q <= 1'b0;
            op_q     <= 1'b0;
        end else begin
            st_q     <= st_d;
            arm_op_q <= arm_op_d;
            op_q     <= op_d;
        end
    end

    // next state
    always_comb begin
        st_d     = st_q;
        arm_op_d = arm_op_q;
        op_d     = 1'b0;
        unique case (st_q)
            ST_RESET: begin
                arm_op_d = 1'b0;
                if (rst_expired)
                    st_d = ST_OFF;
            end
            ST_OFF: begin
                arm_op_d = 1'b0;
                if (wr_rst) begin
                    st_d = ST_RESET;
                end else if (wr_start) begin
                    st_d     = ST_ARM;
                    arm_op_d = wr_op;
                end
            end
            ST_ARM: begin
                if (wr_rst) begin
                    st_d     = ST_RESET;
                    arm_op_d = 1'b0;
                end else if (wr_stop) begin
                    st_d     = ST_OFF;
                    arm_op_d = 1'b0;
                end else if (at_last) begin
                    st_d     = ST_RUN;
                    op_d     = arm_op_q || wr_op;
                    arm_op_d = 1'b0;
                end else if (wr_start) begin
                    arm_op_d = arm_op_q || wr_op;
                end
            end
            ST_RUN: begin
                if (wr_rst)
                    st_d = ST_RESET;
                else if (wr_stop)
                    st_d = ST_DRAIN;
                else if (wr_start)
                    op_d = wr_op;
            end
            ST_DRAIN: begin
                if (wr_rst) begin
                    st_d = ST_RESET;
                end else if (wr_start) begin
                    st_d = ST_RUN;
                    op_d = wr_op;
                end else if (at_last) begin
                    st_d = ST_OFF;
                end
            end
            default: begin
                st_d     = ST_OFF;
                arm_op_d = 1'b0;
            end
        endcase
    end

    // outputs
    always_comb begin
        clk_running = (st_q == ST_RUN) || (st_q == ST_DRAIN);
        resetting   = (st_q == ST_RESET);
        card_ce     = clk_running && at_zero;
        card_phase  = clk_running && phase_hi;
        start_op    = op_q;
    end
endmodule

// File: rtl/cclk_gen.sv
module cclk_gen
    import cclk_pkg::*;
#(
    parameter int DIV_W      = 3,
    parameter int RST_CYCLES = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_we,
    input  logic [CTL_W-1:0] ctrl_wdata,
    input  logic             div_we,
    input  logic [DIV_W-1:0] div_wdata,
    output logic             card_ce,
    output logic             card_phase,
    output logic             clk_running,
    output logic             resetting,
    output logic             start_op
);
    logic [DIV_W-1:0] div_code;
    logic             at_zero, at_last, phase_hi, rst_expired;

    cclk_divider #(.DIV_W(DIV_W)) u_div (
        .clk        (clk),
        .rst_n      (rst_n),
        .code_we    (div_we && !resetting),
        .code_wdata (div_wdata),
        .hold_clr   (resetting),
        .code       (div_code),
        .at_zero    (at_zero),
        .at_last    (at_last),
        .phase_hi   (phase_hi)
    );

    cclk_rst_timer #(.RST_CYCLES(RST_CYCLES)) u_rtim (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (resetting),
        .expired (rst_expired)
    );

    cclk_ctrl_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .ctrl_we     (ctrl_we),
        .ctrl_wdata  (ctrl_wdata),
        .at_zero     (at_zero),
        .at_last     (at_last),
        .phase_hi    (phase_hi),
        .rst_expired (rst_expired),
        .card_ce     (card_ce),
        .card_phase  (card_phase),
        .clk_running (clk_running),
        .resetting   (resetting),
        .start_op    (start_op)
    );
endmodule

// File: rtl/cclk_gen_chk.sv
module cclk_gen_chk #(
    parameter int DIV_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             card_ce,
    input logic             card_phase,
    input logic             clk_running,
    input logic             resetting,
    input logic             start_op,
    input logic [DIV_W-1:0] code
);
    // R2
    ce_needs_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        card_ce |-> clk_running);

    // R3
    on_with_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clk_running) |-> card_ce);

    // R4
    stop_in_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(clk_running) && !resetting && ($past(code) != '0)) |-> !$past(card_phase));

    // R7
    op_with_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_op |-> clk_running);

    // R9
    rst_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resetting |-> (!clk_running && !card_ce && !start_op));
endmodule

bind cclk_gen cclk_gen_chk #(.DIV_W(DIV_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .card_ce     (card_ce),
    .card_phase  (card_phase),
    .clk_running (clk_running),
    .resetting   (resetting),
    .start_op    (start_op),
    .code        (div_code)
);

// File: tb/cclk_gen_test.sv
module cclk_gen_test;
    localparam int RSTC = 8;
    localparam int EV_ON = 0, EV_OFF = 1, EV_OP = 2, EV_RDONE = 3;

    typedef struct {
        int    kind;
        int    cyc;
        string req;
    } ev_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctrl_we = 1'b0;
    logic [3:0] ctrl_wdata = '0;
    logic       div_we = 1'b0;
    logic [2:0] div_wdata = '0;
    logic       card_ce, card_phase, clk_running, resetting, start_op;

    int  cyc = 0;
    int  n_chk = 0;
    int  n_fail = 0;
    int  E = 0;
    int  b_code = 0;
    bit  mon_en = 0;
    bit  prev_run = 0, prev_rst = 0, prev_ph = 0;
    ev_t exp_q[$];

    cclk_gen #(.DIV_W(3), .RST_CYCLES(RSTC)) uut (
        .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
        .div_we(div_we), .div_wdata(div_wdata), .card_ce(card_ce),
        .card_phase(card_phase), .clk_running(clk_running),
        .resetting(resetting), .start_op(start_op)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s cyc=%0d actual=%0d expected=%0d", req, cyc, act, exp);
        end
    endtask

    task automatic push(input int kind, input int c, input string req);
        ev_t e;
        e.kind = kind; e.cyc = c; e.req = req;
        exp_q.push_back(e);
    endtask

    task automatic note(input int kind);
        n_chk++;
        if (exp_q.size() == 0) begin
            n_fail++;
            $display("FAIL unexpected event kind=%0d cyc=%0d actual=%0d expected=none", kind, cyc, kind);
        end else if (exp_q[0].kind != kind || exp_q[0].cyc != cyc) begin
            n_fail++;
            $display("FAIL %s event actual kind=%0d cyc=%0d expected kind=%0d cyc=%0d",
                     exp_q[0].req, kind, cyc, exp_q[0].kind, exp_q[0].cyc);
            void'(exp_q.pop_front());
        end else begin
            void'(exp_q.pop_front());
        end
    endtask

    // monitor: scoreboard comparison of edges of the status outputs
    always @(negedge clk) begin
        if (mon_en) begin
            if (clk_running && !prev_run) note(EV_ON);
            if (!clk_running && prev_run) begin
                note(EV_OFF);
                if (!resetting && b_code != 0)
                    chk(prev_ph == 1'b0, "R4 last-phase", int'(prev_ph), 0);
            end
            if (start_op) note(EV_OP);
            if (prev_rst && !resetting) note(EV_RDONE);
            prev_run = clk_running;
            prev_rst = resetting;
            prev_ph  = card_phase;
        end
    end

    task automatic drv(input bit cwe, input logic [3:0] cd, input bit dwe, input logic [2:0] dc);
        ctrl_we = cwe; ctrl_wdata = cd; div_we = dwe; div_wdata = dc;
        @(negedge clk);
        ctrl_we = 0; ctrl_wdata = '0; div_we = 0; div_wdata = '0;
    endtask

    task automatic wait_until(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    task automatic align_chk(input int n, input string req);
        bit bad = 0;
        int p = 1 << b_code;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            begin
                int  m = (cyc - E) % p;
                bit  ece = (m == 0);
                bit  eph = (p == 1) || (m < p / 2);
                if (!bad && (card_ce !== ece || card_phase !== eph || clk_running !== 1'b1)) begin
                    bad = 1;
                    $display("FAIL %s cyc=%0d actual ce/ph/run=%0b%0b%0b expected=%0b%0b1",
                             req, cyc, card_ce, card_phase, clk_running, ece, eph);
                end
            end
        end
        n_chk++;
        if (bad) n_fail++;
    endtask

    task automatic stay_off(input int n, input string req);
        bit bad = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (clk_running !== 1'b0 || card_ce !== 1'b0) bad = 1;
        end
        chk(!bad, req, int'(bad), 0);
    endtask

    task automatic stop_now(input string req);
        int w = cyc + 1;
        int p = 1 << b_code;
        int c = (w - E) % p;
        push(EV_OFF, w + p - c, req);
        drv(1, 4'b0001, 0, 0);
        wait_until(w + p - c + 1);
        chk(clk_running == 1'b0, req, int'(clk_running), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog cyc=%0d actual=hung expected=done", cyc);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        int w;
        repeat (3) @(negedge clk);
        // R1: outputs low in reset and after release
        chk({card_ce, card_phase, clk_running, resetting, start_op} == 5'b0, "R1 in reset",
            int'({card_ce, card_phase, clk_running, resetting, start_op}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk({card_ce, card_phase, clk_running, resetting, start_op} == 5'b0, "R1 after reset",
            int'({card_ce, card_phase, clk_running, resetting, start_op}), 0);
        mon_en = 1;

        // R3/R7: start with op and code 2, then R2 period
        w = cyc + 1;
        push(EV_ON, w + 4, "R3 start k=2");
        push(EV_OP, w + 4, "R7 op with start");
        E = w; b_code = 2;
        drv(1, 4'b0110, 1, 3'd2);
        wait_until(w + 4);
        chk(card_ce == 1'b1, "R3 first ce", int'(card_ce), 1);
        align_chk(16, "R2 k=2");
        stop_now("R4 stop k=2");

        // R2/R3 with code 0
        w = cyc + 1;
        push(EV_ON, w + 1, "R3 start k=0");
        E = w; b_code = 0;
        drv(1, 4'b0010, 1, 3'd0);
        wait_until(w + 1);
        align_chk(8, "R2 k=0");
        stop_now("R4 stop k=0");

        // R2 with code 7, then R10 start cancels a pending stop
        w = cyc + 1;
        push(EV_ON, w + 128, "R3 start k=7");
        E = w; b_code = 7;
        drv(1, 4'b0010, 1, 3'd7);
        wait_until(w + 128);
        align_chk(256, "R2 k=7");
        while (((cyc + 1 - E) % 128) != 3) @(negedge clk);
        drv(1, 4'b0001, 0, 0);
        drv(1, 4'b0010, 0, 0);
        align_chk(200, "R10 drain cancel");

        // R8 code change while running
        w = cyc + 1;
        E = w; b_code = 3;
        drv(0, 4'b0000, 1, 3'd3);
        chk(card_ce == 1'b1, "R8 restart ce", int'(card_ce), 1);
        align_chk(32, "R8 new period");

        // R7 start+op while running, no restart
        w = cyc + 1;
        push(EV_OP, w, "R7 op while running");
        drv(1, 4'b0110, 0, 0);
        align_chk(24, "R7 no restart");
        stop_now("R4 stop k=3");

        // R6 start and stop together while off
        drv(1, 4'b0011, 0, 0);
        stay_off(40, "R6 stop wins");

        // R5 stop while arming
        E = cyc + 1; b_code = 3;
        drv(1, 4'b0010, 1, 3'd3);
        drv(1, 4'b0001, 0, 0);
        stay_off(30, "R5 stop in arm");

        // R9 reset while running, writes ignored during reset
        w = cyc + 1;
        push(EV_ON, w + 2, "R3 start k=1");
        E = w; b_code = 1;
        drv(1, 4'b0010, 1, 3'd1);
        wait_until(w + 10);
        w = cyc + 1;
        push(EV_OFF, w, "R9 reset stops clock");
        push(EV_RDONE, w + RSTC, "R9 reset length");
        drv(1, 4'b1010, 0, 0);
        chk(resetting == 1'b1, "R9 resetting high", int'(resetting), 1);
        drv(1, 4'b0010, 1, 3'd0);
        wait_until(w + RSTC + 1);
        chk(resetting == 1'b0, "R9 resetting low", int'(resetting), 0);
        stay_off(30, "R9 writes ignored");

        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R3 all events seen", exp_q.size(), 0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule